// File: doc/BRIEF.md
# Master Serial Result Shifter

This block is the serial output stage of a successive-approximation converter. When the interface-select input carries the serial code and the clock-source input selects the internal clock, the block generates its own serial clock, frames each transfer with a SYNC signal, and shifts an 18-bit conversion result out MSB first over exactly 18 clock pulses. It also drives BUSY, which is high from an accepted convert start until the conversion, and in one timing option the transfer, is complete.

Two timing options are available. In read-during-convert, each convert start launches a transfer of the previous result while the new conversion runs, always at the fastest serial rate. In read-after-convert, the transfer of a result begins as soon as that result arrives, BUSY stays high until the last bit has gone out, and a two-bit divider setting can slow the serial clock. The result input is a valid-qualified stream with no ready. The block never applies back-pressure to it. A result is taken in the cycle its valid is high if a conversion is pending, and dropped otherwise. The serial output has no flow control either: the host must follow SCLK.

Top module: `ser_result_shifter`

## Requirements
- R1: After reset BUSY is 0, SDOUT is 0, SCLK equals the SCLK-invert input and SYNC equals the SYNC-invert input. The raw SCLK idles low, and the raw SYNC is active high and idles low.
- R2: A convert start is accepted only when the interface-select input equals 3 and the clock-source input is 0. Otherwise it is ignored: BUSY stays low and no frame appears.
- R3: A convert start is ignored while BUSY is high or while a frame is still being shifted out.
- R4: A frame has raw SYNC high for exactly 18 times the SCLK period. It holds exactly 18 raw SCLK rising edges, and the value of SDOUT at each rising edge gives the result bits MSB first.
- R5: SDOUT stays constant for a whole SCLK period. It changes only together with a falling raw SCLK edge, so each rising edge falls in the middle of a bit.
- R6: In read-during-convert (select input 1), an accepted start launches, in the same cycle, a frame carrying the most recently captured result. There is no frame if nothing has been captured since reset. BUSY falls one cycle after the result valid pulse.
- R7: In read-after-convert (select input 0), a result captured during a pending conversion launches its own frame. BUSY stays high during that frame and falls in the same cycle as the raw SYNC.
- R8: In read-after-convert, divider codes 0, 1, 2 and 3 give SCLK periods of 2, 4, 8 and 16 clocks. In read-during-convert the divider is ignored and the period is 2 clocks.
- R9: SCLK and SYNC are each inverted when their invert input is 1.
- R10: A result valid pulse while no conversion is pending is ignored, and the held result is unchanged.
- R11: The timing option and the divider code are taken at start acceptance. Changes during the conversion have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 2 | Interface select; serial operation at code 3 |
| clk_ext_sel | input | 1 | Clock source; 0 selects the internally generated SCLK |
| rd_during | input | 1 | 1 = read previous result during conversion, 0 = read after conversion |
| sclk_inv | input | 1 | Inverts the SCLK output |
| sync_inv | input | 1 | Inverts the SYNC output |
| sclk_div | input | 2 | SCLK divider code for read-after-convert |
| conv_start | input | 1 | Convert start request |
| res_valid | input | 1 | Conversion done; qualifies res_data |
| res_data | input | 18 | Conversion result |
| sclk_o | output | 1 | Serial clock |
| sdout_o | output | 1 | Serial data |
| sync_o | output | 1 | Frame valid |
| busy_o | output | 1 | Conversion (and read-after transfer) in progress |

## Verification
The hardest situation to reach is a read-during-convert frame still shifting after BUSY has already dropped, because a new start must then be refused even though BUSY is low. The stimulus gets there by sending the result only a few cycles after the start, then pulsing a start at once and checking that BUSY stays low. Between starts, the bench also flips the timing option and divider to their opposite values and sends stray result pulses while idle. The held result and the frame length then show whether any of those leaked in.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  localparam logic [1:0] SER_MODE_CODE = 2'd3;

  typedef enum logic {
    RD_AFTER  = 1'b0,
    RD_DURING = 1'b1
  } rd_timing_e;
endpackage

// File: rtl/ssr_timebase.sv
module ssr_timebase #(
  parameter int BIT_N = 18,
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DIV_W-1:0] div,
  output logic             active,
  output logic             bit_tick,
  output logic             frame_end,
  output logic             sclk_raw
);
  // phase counter wide enough for the longest period
  localparam int PH_W  = 2 ** DIV_W;
  localparam int CNT_W = $clog2(BIT_N);

  logic [PH_W-1:0]  ph_q;
  logic [CNT_W-1:0] bit_q;
  logic [DIV_W-1:0] div_q;
  logic [PH_W:0]    half;
  logic [PH_W:0]    per;

  assign half      = (PH_W+1)'(1) << div_q;
  assign per       = half << 1;
  assign bit_tick  = active && ({1'b0, ph_q} == per - (PH_W+1)'(1));
  assign frame_end = bit_tick && (bit_q == CNT_W'(BIT_N - 1));
  assign sclk_raw  = active && ({1'b0, ph_q} >= half);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      ph_q   <= '0;
      bit_q  <= '0;
      div_q  <= '0;
    end else if (start) begin
      active <= 1'b1;
      ph_q   <= '0;
      bit_q  <= '0;
      div_q  <= div;
    end else if (active) begin
      if (bit_tick) begin
        ph_q  <= '0;
        bit_q <= bit_q + CNT_W'(1);
        if (frame_end) active <= 1'b0;
      end else begin
        ph_q <= ph_q + PH_W'(1);
      end
    end
  end

  AST_BIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (bit_q < CNT_W'(BIT_N))); // R4
  AST_FRAME_ENDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !start) |=> (!active && !sclk_raw)); // R4
endmodule

// File: rtl/ssr_shreg.sv
module ssr_shreg #(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              shift,
  output logic              msb
);
  logic [DATA_W-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr_q <= '0;
    else if (load)  sr_q <= load_data;
    else if (shift) sr_q <= {sr_q[DATA_W-2:0], 1'b0};
  end

  assign msb = sr_q[DATA_W-1];
endmodule

// File: rtl/ssr_ctrl.sv
module ssr_ctrl
  import ssr_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int DIV_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              conv_start,
  input  logic              rd_during,
  input  logic [DIV_W-1:0]  div_in,
  input  logic              res_valid,
  input  logic [DATA_W-1:0] res_data,
  input  logic              frame_active,
  input  logic              frame_end,
  output logic              busy,
  output logic              launch,
  output logic [DATA_W-1:0] launch_data,
  output logic [DIV_W-1:0]  launch_div
);
  rd_timing_e        cfg_rd_q;
  logic [DIV_W-1:0]  cfg_div_q;
  logic              pending_q;
  logic              have_prev_q;
  logic [DATA_W-1:0] hold_q;
  logic              accept;
  logic              capture;

  assign accept  = en && conv_start && !busy && !frame_active;
  assign capture = res_valid && pending_q;

  assign launch      = (accept && rd_during && have_prev_q) ||
                       (capture && (cfg_rd_q == RD_AFTER));
  assign launch_data = accept ? hold_q : res_data;
  assign launch_div  = accept ? '0 : cfg_div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      cfg_rd_q    <= RD_AFTER;
      cfg_div_q   <= '0;
      pending_q   <= 1'b0;
      have_prev_q <= 1'b0;
      hold_q      <= '0;
    end else begin
      if (accept) begin
        busy      <= 1'b1;
        pending_q <= 1'b1;
        cfg_rd_q  <= rd_during ? RD_DURING : RD_AFTER;
        cfg_div_q <= rd_during ? '0 : div_in;
      end
      if (capture) begin
        pending_q   <= 1'b0;
        have_prev_q <= 1'b1;
        hold_q      <= res_data;
        if (cfg_rd_q == RD_DURING) busy <= 1'b0;
      end
      if ((cfg_rd_q == RD_AFTER) && !pending_q && frame_end) busy <= 1'b0;
    end
  end

  AST_DURING_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && (cfg_rd_q == RD_DURING)) |=> !busy); // R6
  AST_AFTER_FRAME_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_active && (cfg_rd_q == RD_AFTER)) |-> busy); // R7
  AST_PENDING_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    pending_q |-> busy); // R10
endmodule

// File: rtl/ser_result_shifter.sv
module ser_result_shifter
  import ssr_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int DIV_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_sel,
  input  logic              clk_ext_sel,
  input  logic              rd_during,
  input  logic              sclk_inv,
  input  logic              sync_inv,
  input  logic [DIV_W-1:0]  sclk_div,
  input  logic              conv_start,
  input  logic              res_valid,
  input  logic [DATA_W-1:0] res_data,
  output logic              sclk_o,
  output logic              sdout_o,
  output logic              sync_o,
  output logic              busy_o
);
  logic              en;
  logic              launch;
  logic [DATA_W-1:0] launch_data;
  logic [DIV_W-1:0]  launch_div;
  logic              active;
  logic              bit_tick;
  logic              frame_end;
  logic              sclk_raw;
  logic              msb;

  assign en = (mode_sel == SER_MODE_CODE) && !clk_ext_sel;

  ssr_ctrl #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .en(en), .conv_start(conv_start),
    .rd_during(rd_during), .div_in(sclk_div), .res_valid(res_valid),
    .res_data(res_data), .frame_active(active), .frame_end(frame_end),
    .busy(busy_o), .launch(launch), .launch_data(launch_data),
    .launch_div(launch_div)
  );

  ssr_timebase #(.BIT_N(DATA_W), .DIV_W(DIV_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .start(launch), .div(launch_div),
    .active(active), .bit_tick(bit_tick), .frame_end(frame_end),
    .sclk_raw(sclk_raw)
  );

  ssr_shreg #(.DATA_W(DATA_W)) u_sr (
    .clk(clk), .rst_n(rst_n), .load(launch), .load_data(launch_data),
    .shift(bit_tick), .msb(msb)
  );

  assign sclk_o  = sclk_raw ^ sclk_inv;
  assign sync_o  = active ^ sync_inv;
  assign sdout_o = active & msb;

  AST_SDOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && !$past(bit_tick)) |-> $stable(sdout_o)); // R5
  AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(conv_start && en)); // R2
  AST_LAUNCH_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> !active); // R3
endmodule

// File: tb/ser_result_shifter_tb.sv
module ser_result_shifter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_sel = 2'd3;
  logic        clk_ext_sel = 1'b0;
  logic        rd_during = 1'b0;
  logic        sclk_inv = 1'b0;
  logic        sync_inv = 1'b0;
  logic [1:0]  sclk_div = 2'd0;
  logic        conv_start = 1'b0;
  logic        res_valid = 1'b0;
  logic [17:0] res_data = '0;
  logic        sclk_o, sdout_o, sync_o, busy_o;

  always #4 clk = ~clk;

  ser_result_shifter u_dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .clk_ext_sel(clk_ext_sel),
    .rd_during(rd_during), .sclk_inv(sclk_inv), .sync_inv(sync_inv),
    .sclk_div(sclk_div), .conv_start(conv_start), .res_valid(res_valid),
    .res_data(res_data), .sclk_o(sclk_o), .sdout_o(sdout_o),
    .sync_o(sync_o), .busy_o(busy_o)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [17:0] prev_m = '0;
  bit          have_prev_m = 1'b0;

  // frame monitor state
  int          frame_cnt = 0;
  int          cur_len = 0, cur_rises = 0;
  logic [17:0] cur_bits = '0;
  bit          cur_stable = 1'b1;
  int          last_len = 0, last_rises = 0;
  logic [17:0] last_bits = '0;
  bit          last_stable = 1'b1;
  int          sync_end_cyc = -1, busy_fall_cyc = -2;
  bit          p_sync = 1'b0, p_sclk = 1'b0, p_sdo = 1'b0, p_busy = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    bit s, k;
    #2;
    s = sync_o ^ sync_inv;
    k = sclk_o ^ sclk_inv;
    if (s && !p_sync) begin
      cur_len = 1; cur_rises = 0; cur_bits = '0; cur_stable = 1'b1;
    end else if (s) begin
      cur_len++;
      if (sdout_o != p_sdo && !(p_sclk && !k)) cur_stable = 1'b0;
      if (k && !p_sclk) begin
        cur_rises++;
        cur_bits = {cur_bits[16:0], sdout_o};
      end
    end
    if (!s && p_sync) begin
      frame_cnt++;
      last_len = cur_len; last_rises = cur_rises;
      last_bits = cur_bits; last_stable = cur_stable;
      sync_end_cyc = cyc;
    end
    if (!busy_o && p_busy) busy_fall_cyc = cyc;
    p_sync = s; p_sclk = k; p_sdo = sdout_o; p_busy = busy_o;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy_o || (sync_o ^ sync_inv)) @(negedge clk);
    @(negedge clk);
  endtask

  // one conversion; dup adds a start pulse while busy
  task automatic conv_cycle(input bit rdc, input bit [1:0] dv, input bit [17:0] data,
                            input int gap, input bit dup);
    int f0;
    bit exp_frame;
    logic [17:0] exp_bits;
    int exp_len;
    wait_idle();
    f0 = frame_cnt;
    exp_frame = rdc ? have_prev_m : 1'b1;
    exp_bits  = rdc ? prev_m : data;
    exp_len   = 18 * (rdc ? 2 : (2 << dv));
    rd_during = rdc; sclk_div = dv;
    @(negedge clk) conv_start = 1'b1;
    @(negedge clk) conv_start = 1'b0;
    check(busy_o == 1'b1, "R2 busy after start", busy_o, 1);
    // R11: flip the configuration while converting
    rd_during = ~rdc; sclk_div = ~dv;
    if (dup) begin
      @(negedge clk) conv_start = 1'b1;   // R3 start while busy
      @(negedge clk) conv_start = 1'b0;
    end
    repeat (gap) @(negedge clk);
    res_valid = 1'b1; res_data = data;
    @(negedge clk) res_valid = 1'b0;
    if (rdc) check(busy_o == 1'b0, "R6 busy falls after result", busy_o, 0);
    else     check(busy_o == 1'b1, "R7 busy held for transfer", busy_o, 1);
    prev_m = data; have_prev_m = 1'b1;
    wait_idle();
    check(frame_cnt == f0 + int'(exp_frame), rdc ? "R6 frame count" : "R7 frame count",
          frame_cnt - f0, exp_frame);
    if (exp_frame) begin
      check(last_bits == exp_bits, "R4 frame data", last_bits, exp_bits);
      check(last_rises == 18, "R4 sclk rising edges", last_rises, 18);
      check(last_len == exp_len, "R8 R11 frame length", last_len, exp_len);
      check(last_stable, "R5 sdout stable within period", last_stable, 1);
      if (!rdc) check(sync_end_cyc == busy_fall_cyc, "R7 busy ends with sync",
                      busy_fall_cyc, sync_end_cyc);
    end
  endtask

  task automatic reject_start(input bit [1:0] m, input bit ext);
    int f0;
    wait_idle();
    f0 = frame_cnt;
    mode_sel = m; clk_ext_sel = ext;
    @(negedge clk) conv_start = 1'b1;
    @(negedge clk) conv_start = 1'b0;
    repeat (3) @(negedge clk);
    check(busy_o == 1'b0, "R2 start ignored when not serial/internal", busy_o, 0);
    check(frame_cnt == f0 && !(sync_o ^ sync_inv), "R2 no frame", frame_cnt - f0, 0);
    mode_sel = 2'd3; clk_ext_sel = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h1234_5eed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(busy_o == 0, "R1 busy reset", busy_o, 0);
    check(sclk_o == 0, "R1 sclk idle", sclk_o, 0);
    check(sync_o == 0, "R1 sync idle", sync_o, 0);
    check(sdout_o == 0, "R1 sdout idle", sdout_o, 0);

    // R6: first read-during conversion has no previous result
    conv_cycle(1'b1, 2'd3, 18'h2A5C3, 10, 1'b0);
    // R7 R8 read-after at each divider code
    conv_cycle(1'b0, 2'd0, 18'h3FFFF, 5, 1'b0);
    conv_cycle(1'b0, 2'd1, 18'h20001, 7, 1'b0);
    conv_cycle(1'b0, 2'd2, 18'h15555, 4, 1'b0);
    conv_cycle(1'b0, 2'd3, 18'h0ACE1, 6, 1'b0);
    // R6 R8 read-during with divider 3 ignored
    conv_cycle(1'b1, 2'd3, 18'h00001, 50, 1'b0);
    // R3 extra start while busy
    conv_cycle(1'b0, 2'd1, 18'h1BEEF, 8, 1'b1);
    conv_cycle(1'b1, 2'd0, 18'h2C0DE, 8, 1'b1);

    // R3 start while read-during frame still shifts but busy low
    wait_idle();
    rd_during = 1'b1;
    @(negedge clk) conv_start = 1'b1;
    @(negedge clk) conv_start = 1'b0;
    repeat (2) @(negedge clk);
    res_valid = 1'b1; res_data = 18'h01234;
    @(negedge clk) res_valid = 1'b0;
    prev_m = 18'h01234;
    conv_start = 1'b1;
    @(negedge clk) conv_start = 1'b0;
    @(negedge clk);
    check(busy_o == 1'b0, "R3 start ignored during frame", busy_o, 0);

    // R2 wrong mode or external clock
    reject_start(2'd1, 1'b0);
    reject_start(2'd3, 1'b1);

    // R10 stray result while idle does not replace held result
    wait_idle();
    res_valid = 1'b1; res_data = 18'h3A3A3;
    @(negedge clk) res_valid = 1'b0;
    repeat (2) @(negedge clk);
    check(busy_o == 0 && !(sync_o ^ sync_inv), "R10 stray result no frame", busy_o, 0);
    conv_cycle(1'b1, 2'd0, 18'h11111, 40, 1'b0);

    // R9 inversion
    wait_idle();
    @(negedge clk) begin sclk_inv = 1'b1; sync_inv = 1'b1; end
    @(negedge clk);
    check(sclk_o == 1, "R9 sclk inverted idle", sclk_o, 1);
    check(sync_o == 1, "R9 sync inverted idle", sync_o, 1);
    conv_cycle(1'b0, 2'd1, 18'h24681, 3, 1'b0);

    // random mix
    for (int i = 0; i < 24; i++) begin
      bit rdc, si, ki;
      bit [1:0] dv;
      bit [17:0] d;
      wait_idle();
      si = 1'($urandom); ki = 1'($urandom);
      @(negedge clk) begin sync_inv = si; sclk_inv = ki; end
      rdc = 1'($urandom);
      dv  = 2'($urandom);
      d   = 18'($urandom);
      conv_cycle(rdc, dv, d, 3 + int'($urandom % 60), 1'($urandom));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule